// File: doc/BRIEF.md
# Ping-Pong Bus-to-DAC Sample Packer

This block sits between a processor-style write bus and a bank of output serializers feeding a 14-bit DAC. Every 32-bit bus word carries two samples, one for channel 0 in the low half and one for channel 1 in the upper half. The low bit of the word address steers the write into one of two equal memories, even or odd. The remaining address bits give the location inside the chosen memory. A program can therefore fill the buffer with plain consecutive word addresses and then go on with other work.

A read clock at half the write rate drives the read side. On each read cycle it fetches the same location from both memories at once, which gives four samples. Two consecutive reads are combined into one 112-bit group of eight samples. The group is presented with a single-cycle load strobe on every second read cycle, which is the parallel load rate the serializers expect. The read location comes from a free-running counter. It restarts at zero whenever the block leaves reset and wraps at the top of the memory. The write port has no reset, so the buffer can be filled while the read side is held in reset.

Top module: `dac_pair_packer`

## Requirements
- R1: When `wr_en` is high, a write with `wr_addr[0]`=0 goes to the even memory and a write with `wr_addr[0]`=1 goes to the odd memory. In both cases `wr_addr[11:1]` selects the location.
- R2: A written word stores channel 0 from `wr_data[13:0]` and channel 1 from `wr_data[29:16]`. Bits 15:14 and 31:30 have no effect on any output.
- R3: A write cycle with `wr_en` low leaves both memories unchanged.
- R4: Each read cycle fetches one location from both memories together. The location starts at 0 after reset, rises by one per read-clock cycle and wraps from 2047 back to 0.
- R5: Sample lane i of a group sits at `grp_data[14*i+13:14*i]`. Lanes 0 to 3 come from location 2k and lanes 4 to 7 from location 2k+1, in the order even channel 0, even channel 1, odd channel 0, odd channel 1 for each of the two locations. Under sequential word writes, lane i of group k therefore holds sample 8k+i.
- R6: `grp_load` is high for exactly one read-clock cycle in every two. `grp_data` changes only in cycles where `grp_load` is high.
- R7: While `rst_n` is low, `grp_load` is 0 and `grp_data` is 0, and writes are still stored. After `rst_n` rises, the first `grp_load` appears on the fifth rising `rd_clk` edge and carries locations 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Bus write clock |
| rd_clk | input | 1 | Read clock, half the write rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously on the read side |
| wr_en | input | 1 | Write enable for the current bus word |
| wr_addr | input | 12 | Word address; bit 0 selects the memory |
| wr_data | input | 32 | Bus word holding two samples |
| grp_data | output | 112 | Eight packed samples for one serializer load |
| grp_load | output | 1 | One-cycle strobe marking a new group |

## Verification
A wrong read counter shows up at the very next load strobe, within two read cycles, as a group that breaks the counting sequence. A read phase flag that is wrong swaps the two halves of every group, or shifts the strobe by one cycle, so the first group after reset already exposes it. A steering or channel-slice error moves a known sample into the wrong lane of the first group that covers the affected address. Because the bench fills the whole buffer and follows it past the wrap, every location is compared once against the sequence it should hold.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

  // Which half of a group the read word just fetched belongs to
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;

  localparam int unsigned BANK_COUNT = 2;
  localparam int unsigned READS_PER_GROUP = 2;

endpackage

// File: rtl/dpk_rst_sync.sv
module dpk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/dpk_bank.sv
module dpk_bank #(
  parameter int unsigned WORD_W = 28,
  parameter int unsigned LOC_W  = 11
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [LOC_W-1:0]  wr_loc,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_clk,
  input  logic [LOC_W-1:0]  rd_loc,
  output logic [WORD_W-1:0] rd_word
);

  localparam int unsigned DEPTH = 1 << LOC_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_word_q;

  // write port: memory array carries no reset
  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      mem[wr_loc] <= wr_word;
    end
  end

  // registered read port on the slow clock
  always_ff @(posedge rd_clk) begin
    rd_word_q <= mem[rd_loc];
  end

  assign rd_word = rd_word_q;

endmodule

// File: rtl/dpk_rd_seq.sv
module dpk_rd_seq
  import dpk_pkg::*;
#(
  parameter int unsigned LOC_W = 11
) (
  input  logic             rd_clk,
  input  logic             rst_n,
  output logic [LOC_W-1:0] rd_loc,
  output logic             rd_vld,
  output half_e            rd_half
);

  logic [LOC_W-1:0] loc_q;
  logic [LOC_W-1:0] loc_nxt;
  logic             vld_q;
  half_e            half_q;
  half_e            half_nxt;

  always_comb begin
    loc_nxt  = loc_q + LOC_W'(1);
    half_nxt = half_e'(loc_q[0]);
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      vld_q  <= 1'b0;
      half_q <= HALF_LO;
    end else begin
      loc_q  <= loc_nxt;
      vld_q  <= 1'b1;
      half_q <= half_nxt;
    end
  end

  assign rd_loc  = loc_q;
  assign rd_vld  = vld_q;
  assign rd_half = half_q;

endmodule

// File: rtl/dpk_assembler.sv
module dpk_assembler
  import dpk_pkg::*;
#(
  parameter int unsigned READ_W = 56
) (
  input  logic                           rd_clk,
  input  logic                           rst_n,
  input  logic                           rd_vld,
  input  half_e                          rd_half,
  input  logic [READ_W-1:0]              rd_word,
  output logic [READS_PER_GROUP*READ_W-1:0] grp_data,
  output logic                           grp_load
);

  localparam int unsigned GROUP_W = READS_PER_GROUP * READ_W;

  logic [READ_W-1:0]  hold_q;
  logic [READ_W-1:0]  hold_nxt;
  logic               hold_en;
  logic [GROUP_W-1:0] grp_q;
  logic [GROUP_W-1:0] grp_nxt;
  logic               grp_en;
  logic               load_q;

  always_comb begin
    hold_en  = rd_vld && (rd_half == HALF_LO);
    grp_en   = rd_vld && (rd_half == HALF_HI);
    hold_nxt = rd_word;
    // second read fills the upper lanes
    grp_nxt  = {rd_word, hold_q};
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      grp_q  <= '0;
      load_q <= 1'b0;
    end else begin
      if (hold_en) begin
        hold_q <= hold_nxt;
      end
      if (grp_en) begin
        grp_q <= grp_nxt;
      end
      load_q <= grp_en;
    end
  end

  assign grp_data = grp_q;
  assign grp_load = load_q;

endmodule

// File: rtl/dac_pair_packer.sv
module dac_pair_packer
  import dpk_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 14,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned CH1_LSB  = 16,
  parameter int unsigned ADDR_W   = 12
) (
  input  logic                wr_clk,
  input  logic                rd_clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [BUS_W-1:0]    wr_data,
  output logic [READS_PER_GROUP*BANK_COUNT*2*SAMPLE_W-1:0] grp_data,
  output logic                grp_load
);

  localparam int unsigned LOC_W   = ADDR_W - 1;
  localparam int unsigned BANK_W  = 2 * SAMPLE_W;
  localparam int unsigned READ_W  = BANK_COUNT * BANK_W;
  localparam int unsigned GROUP_W = READS_PER_GROUP * READ_W;

  logic                rd_rst_n;
  logic [BANK_W-1:0]   bank_wr_word;
  logic [LOC_W-1:0]    wr_loc;
  logic [LOC_W-1:0]    rd_loc;
  logic                rd_vld;
  half_e               rd_half;
  logic [READ_W-1:0]   rd_word;
  logic                unused_bits;

  // channel slices of the bus word: {ch1, ch0}
  assign bank_wr_word = {wr_data[CH1_LSB +: SAMPLE_W], wr_data[0 +: SAMPLE_W]};
  assign wr_loc       = wr_addr[ADDR_W-1:1];
  assign unused_bits  = ^{wr_data[BUS_W-1:CH1_LSB+SAMPLE_W], wr_data[CH1_LSB-1:SAMPLE_W]};

  dpk_rst_sync u_rst_sync (
    .clk        (rd_clk),
    .rst_n      (rst_n),
    .rst_n_sync (rd_rst_n)
  );

  dpk_rd_seq #(
    .LOC_W (LOC_W)
  ) u_rd_seq (
    .rd_clk  (rd_clk),
    .rst_n   (rd_rst_n),
    .rd_loc  (rd_loc),
    .rd_vld  (rd_vld),
    .rd_half (rd_half)
  );

  // bank 0 takes even word addresses, bank 1 odd ones
  for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
    logic bank_we;
    logic [BANK_W-1:0] bank_rd;

    assign bank_we = wr_en && (wr_addr[0] == b[0]);

    dpk_bank #(
      .WORD_W (BANK_W),
      .LOC_W  (LOC_W)
    ) u_bank (
      .wr_clk  (wr_clk),
      .wr_en   (bank_we),
      .wr_loc  (wr_loc),
      .wr_word (bank_wr_word),
      .rd_clk  (rd_clk),
      .rd_loc  (rd_loc),
      .rd_word (bank_rd)
    );

    assign rd_word[b*BANK_W +: BANK_W] = bank_rd;
  end

  dpk_assembler #(
    .READ_W (READ_W)
  ) u_assembler (
    .rd_clk   (rd_clk),
    .rst_n    (rd_rst_n),
    .rd_vld   (rd_vld),
    .rd_half  (rd_half),
    .rd_word  (rd_word),
    .grp_data (grp_data),
    .grp_load (grp_load)
  );

endmodule

// File: rtl/dpk_checker.sv
module dpk_checker #(
  parameter int unsigned GROUP_W = 112,
  parameter int unsigned LOC_W   = 11
) (
  input logic               rd_clk,
  input logic               rst_n,
  input logic               grp_load,
  input logic [GROUP_W-1:0] grp_data,
  input logic [LOC_W-1:0]   rd_loc
);

  // R6
  load_single_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    grp_load |=> !grp_load);

  // R6
  load_period_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    grp_load |-> ##2 grp_load);

  // R6
  group_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !grp_load |-> $stable(grp_data));

  // R4
  loc_step_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_loc != '0) |-> (rd_loc == LOC_W'($past(rd_loc) + 1'b1)));

  // R7
  reset_quiet_chk: assert property (@(posedge rd_clk)
    !rst_n |-> (!grp_load && (grp_data == '0)));

endmodule

bind dac_pair_packer dpk_checker #(
  .GROUP_W (GROUP_W),
  .LOC_W   (LOC_W)
) u_chk (
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .grp_load (grp_load),
  .grp_data (grp_data),
  .rd_loc   (rd_loc)
);

// File: tb/dac_pair_packer_test.sv
module dac_pair_packer_test;

  localparam int NWORDS   = 4096;
  localparam int NSAMPLES = 2 * NWORDS;

  logic         wr_clk = 1'b0;
  logic         rd_clk = 1'b0;
  logic         rst_n  = 1'b0;
  logic         wr_en  = 1'b0;
  logic [11:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [111:0] grp_data;
  logic         grp_load;

  int checks = 0;
  int errors = 0;
  logic [13:0] model [NSAMPLES];

  always #4 wr_clk = ~wr_clk;
  always #8 rd_clk = ~rd_clk;

  dac_pair_packer uut (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .grp_data (grp_data),
    .grp_load (grp_load)
  );

  task automatic check_val(input string req, input logic [111:0] act, input logic [111:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [111:0] exp_group(input int g);
    logic [111:0] r;
    for (int i = 0; i < 8; i++) begin
      r[14*i +: 14] = model[(8*g + i) % NSAMPLES];
    end
    return r;
  endfunction

  task automatic bus_write(input int a, input logic [31:0] d, input logic en);
    @(negedge wr_clk);
    wr_addr = a[11:0];
    wr_data = d;
    wr_en   = en;
    if (en) begin
      model[2*a]   = d[13:0];
      model[2*a+1] = d[29:16];
    end
    @(posedge wr_clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic enter_reset();
    @(negedge rd_clk);
    rst_n = 1'b0;
    repeat (2) @(negedge rd_clk);
  endtask

  // release reset, check first load timing, then follow n more groups
  task automatic run_groups(input int n, input string req);
    @(negedge rd_clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 5; e++) begin
      @(negedge rd_clk);
      if (e < 5) check_val("R7 no load before fifth edge", {111'd0, grp_load}, 112'd0);
    end
    check_val("R7 first load on fifth edge", {111'd0, grp_load}, 112'd1);
    check_val({req, " group 0"}, grp_data, exp_group(0));
    for (int g = 1; g <= n; g++) begin
      @(negedge rd_clk);
      check_val("R6 strobe low between loads", {111'd0, grp_load}, 112'd0);
      @(negedge rd_clk);
      check_val("R6 strobe every second cycle", {111'd0, grp_load}, 112'd1);
      check_val(req, grp_data, exp_group(g));
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge rd_clk);
    check_val("R7 reset load low", {111'd0, grp_load}, 112'd0);
    check_val("R7 reset data zero", grp_data, 112'd0);
  endtask

  task automatic t_counting_wrap();
    enter_reset();
    for (int a = 0; a < NWORDS; a++) begin
      bus_write(a, {2'b00, 14'(2*a+1), 2'b00, 14'(2*a)}, 1'b1);
    end
    check_val("R7 load low while filling in reset", {111'd0, grp_load}, 112'd0);
    // 1024 groups cover the memory; follow past the wrap (R4, R5)
    run_groups(1030, "R5 R4 counting order and wrap");
  endtask

  task automatic t_ignored_bits();
    enter_reset();
    for (int a = 0; a < 64; a++) begin
      bus_write(a, {2'b11, 14'(3*a+7), 2'b11, 14'(5*a+1)}, 1'b1);
    end
    // disabled writes must not land (R3)
    for (int a = 0; a < 16; a++) begin
      bus_write(a, 32'h3FFF_3FFF, 1'b0);
    end
    run_groups(7, "R2 R3 padding bits and disabled writes");
  endtask

  task automatic t_parity();
    enter_reset();
    bus_write(5, {2'b00, 14'h1555, 2'b00, 14'h2AAA}, 1'b1);
    bus_write(8, {2'b00, 14'h30F0, 2'b00, 14'h0F0F}, 1'b1);
    run_groups(3, "R1 bank steering");
    // odd word 5 sits in group 1 lanes 2,3; even word 8 in group 2 lanes 0,1
    check_val("R1 odd word lanes", {84'd0, exp_group(1)[55:28]}, {84'd0, 14'h1555, 14'h2AAA});
    check_val("R1 even word lanes", {84'd0, exp_group(2)[27:0]}, {84'd0, 14'h30F0, 14'h0F0F});
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSAMPLES; i++) model[i] = '0;
    t_reset_state();
    t_counting_wrap();
    t_ignored_bits();
    t_parity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule